// File: doc/BRIEF.md
# Shared Reset Line Pushbutton Detector

This block owns one shared, active-low, open-drain reset line with a pull-up. The supervisor pulls the line low whenever an internal supply fault asks for a reset. A pushbutton wired straight onto the same line may also pull it low. The block watches the synchronised line level. While its own drive is off, it treats a sustained low as a manual reset request.

A press must outlast a short glitch filter. After that, the line is masked for one debounce window, so contact bounce cannot end the press early. The release must then stay high for a full debounce window, and any low during that window starts the window again. Once the release is accepted, the block drives the line low itself for the manual reset timeout. After it lets go, the line is not watched for a short settle window, so the block never reads back its own drive or the slow rise through the pull-up as a new press.

All durations are counted in clock cycles. The defaults suit a 125 MHz clock: about 0.5 µs of glitch filtering, about 56 ms of debounce and about 225 ms of timeout.

Top module: `pbl_top`

## Requirements
- R1: While `rst_ni` is low, `drive_low_o` is 1. With no fault requested, `drive_low_o` goes to 0 on the first clock edge after reset is released.
- R2: Outside a manual timeout, `drive_low_o` equals `fault_req_i` delayed by one clock cycle.
- R3: An external low on the line that lasts GLITCH_CYC cycles or fewer leaves `drive_low_o` at 0.
- R4: An external low that lasts GLITCH_CYC+1 cycles or more is recognised as a press, even a short tap. After the release, it leads to a manual timeout.
- R5: For DEB_CYC cycles after a press is recognised, the line level is ignored. Bounce in that window neither ends nor restarts the press.
- R6: A release is accepted only after DEB_CYC+1 consecutive high samples. Any low sample during that window starts the count again.
- R7: The manual timeout makes `drive_low_o` 1 for exactly TMO_CYC cycles. It starts SYNC_STAGES+DEB_CYC clock edges after the edge at which the final high level of the line is first sampled, and never sooner than a clean tap allows.
- R8: A low line caused by the block's own drive never starts a press. When a fault ends, `drive_low_o` returns to 0 and stays there.
- R9: After `drive_low_o` falls, the line is not examined for SETTLE_CYC cycles. A press that starts and ends inside that window is ignored, and a press still held at the end of the window is recognised.
- R10: A fault request during press tracking cancels the tracking. A fault request that outlasts a manual timeout keeps `drive_low_o` at 1 until one cycle after the fault ends.
- R11: A button still held when a fault ends is recognised again once the settle window has passed. Its release then gives a full manual timeout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fault_req_i | input | 1 | Internal supply fault reset request, active high |
| line_lvl_i | input | 1 | Sampled level of the shared reset line, 1 = high |
| drive_low_o | output | 1 | 1 enables the open-drain pull-down of the line |

## Verification
Two cases are hard to reach from the ports. In the first, a fault ends while the button is still held, so the line never rises and the press must be picked up again after the settle window. In the second, a press starts in the very cycle the block lets go of the line. The bench models the wire as the AND of the pull-up with both pull-downs. It times the button and fault edges against the drive edges it predicts itself, so these overlaps happen on exact cycles. Bounce patterns are placed on both sides of the press mask, so that a mask that is too short or a release count that is not restarted moves the predicted rise edge.

// File: rtl/pbl_pkg.sv
package pbl_pkg;

    typedef enum logic [2:0] {
        ST_SETTLE = 3'd0,
        ST_IDLE   = 3'd1,
        ST_QUAL   = 3'd2,
        ST_PRESS  = 3'd3,
        ST_HELD   = 3'd4,
        ST_REL    = 3'd5,
        ST_HOLD   = 3'd6
    } pbl_state_e;

    function automatic int unsigned pbl_max(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pbl_sync.sv
module pbl_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    generate
        if (STAGES == 1) begin : g_one
            assign chain_d = d_i;
        end else begin : g_many
            assign chain_d = {chain_q[STAGES-2:0], d_i};
        end
    endgenerate

    // reset to the idle (high) level of the line
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '1;
        else         chain_q <= chain_d;
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pbl_fsm.sv
module pbl_fsm
    import pbl_pkg::*;
#(
    parameter int unsigned GLITCH_CYC = 63,
    parameter int unsigned DEB_CYC    = 7031250,
    parameter int unsigned TMO_CYC    = 28125000,
    parameter int unsigned SETTLE_CYC = 8
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       fault_i,
    input  logic       line_i,
    output logic       hold_nxt_o,
    output pbl_state_e st_o
);
    localparam int unsigned MAXC = pbl_max(pbl_max(GLITCH_CYC, DEB_CYC),
                                           pbl_max(TMO_CYC, SETTLE_CYC));
    localparam int unsigned CW   = $clog2(MAXC + 1);

    localparam logic [CW-1:0] L_GLT = CW'(GLITCH_CYC - 1);
    localparam logic [CW-1:0] L_DEB = CW'(DEB_CYC - 1);
    localparam logic [CW-1:0] L_TMO = CW'(TMO_CYC - 1);
    localparam logic [CW-1:0] L_SET = CW'(SETTLE_CYC - 1);

    typedef struct packed {
        pbl_state_e    st;
        logic [CW-1:0] cnt;
    } fsm_t;

    fsm_t cur_q, nxt_d;
    logic watching;
    logic cnt_zero;
    logic [CW-1:0] cnt_dec;

    assign cnt_zero = (cur_q.cnt == '0);
    assign cnt_dec  = cur_q.cnt - CW'(1);

    // states in which the block's drive is off and the line is observed
    assign watching = (cur_q.st == ST_IDLE) || (cur_q.st == ST_QUAL) ||
                      (cur_q.st == ST_PRESS) || (cur_q.st == ST_HELD) ||
                      (cur_q.st == ST_REL);

    always_comb begin
        nxt_d = cur_q;
        unique case (cur_q.st)
            ST_SETTLE: begin
                if (fault_i)       nxt_d.cnt = L_SET;
                else if (cnt_zero) nxt_d.st  = ST_IDLE;
                else               nxt_d.cnt = cnt_dec;
            end
            ST_IDLE: begin
                if (!line_i) begin
                    nxt_d.st  = ST_QUAL;
                    nxt_d.cnt = L_GLT;
                end
            end
            ST_QUAL: begin
                if (line_i) begin
                    nxt_d.st = ST_IDLE;
                end else if (cnt_zero) begin
                    nxt_d.st  = ST_PRESS;
                    nxt_d.cnt = L_DEB;
                end else begin
                    nxt_d.cnt = cnt_dec;
                end
            end
            ST_PRESS: begin
                // line masked: contact bounce after the press
                if (cnt_zero) nxt_d.st  = ST_HELD;
                else          nxt_d.cnt = cnt_dec;
            end
            ST_HELD: begin
                if (line_i) begin
                    nxt_d.st  = ST_REL;
                    nxt_d.cnt = L_DEB;
                end
            end
            ST_REL: begin
                if (!line_i) begin
                    nxt_d.st = ST_HELD;
                end else if (cnt_zero) begin
                    nxt_d.st  = ST_HOLD;
                    nxt_d.cnt = L_TMO;
                end else begin
                    nxt_d.cnt = cnt_dec;
                end
            end
            ST_HOLD: begin
                if (cnt_zero) begin
                    nxt_d.st  = ST_SETTLE;
                    nxt_d.cnt = L_SET;
                end else begin
                    nxt_d.cnt = cnt_dec;
                end
            end
            default: begin
                nxt_d.st  = ST_SETTLE;
                nxt_d.cnt = L_SET;
            end
        endcase
        if (fault_i && watching) begin
            nxt_d.st  = ST_SETTLE;
            nxt_d.cnt = L_SET;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cur_q.st  <= ST_SETTLE;
            cur_q.cnt <= L_SET;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign hold_nxt_o = (nxt_d.st == ST_HOLD);
    assign st_o       = cur_q.st;
endmodule

// File: rtl/pbl_drive.sv
module pbl_drive (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic fault_i,
    input  logic hold_nxt_i,
    output logic drive_o
);
    logic drive_d, drive_q;

    always_comb begin
        drive_d = fault_i | hold_nxt_i;
    end

    // line held low during reset
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) drive_q <= 1'b1;
        else         drive_q <= drive_d;
    end

    assign drive_o = drive_q;
endmodule

// File: rtl/pbl_top.sv
module pbl_top
    import pbl_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned GLITCH_CYC  = 63,
    parameter int unsigned DEB_CYC     = 7031250,
    parameter int unsigned TMO_CYC     = 28125000,
    parameter int unsigned SETTLE_CYC  = 8
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic fault_req_i,
    input  logic line_lvl_i,
    output logic drive_low_o
);
    logic       line_s;
    logic       hold_nxt;
    pbl_state_e st_w;

    pbl_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   (line_lvl_i),
        .q_o   (line_s)
    );

    pbl_fsm #(
        .GLITCH_CYC(GLITCH_CYC),
        .DEB_CYC   (DEB_CYC),
        .TMO_CYC   (TMO_CYC),
        .SETTLE_CYC(SETTLE_CYC)
    ) u_fsm (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .fault_i   (fault_req_i),
        .line_i    (line_s),
        .hold_nxt_o(hold_nxt),
        .st_o      (st_w)
    );

    pbl_drive u_drive (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .fault_i   (fault_req_i),
        .hold_nxt_i(hold_nxt),
        .drive_o   (drive_low_o)
    );
endmodule

// File: rtl/pbl_chk.sv
module pbl_chk
    import pbl_pkg::*;
#(
    parameter int unsigned TMO_CYC    = 28125000,
    parameter int unsigned SETTLE_CYC = 8
) (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       fault_i,
    input logic       drive_i,
    input pbl_state_e st_i
);
    logic in_hold;
    logic up_q;
    int   hold_len_q;
    int   lowrun_q;

    assign in_hold = (st_i == ST_HOLD);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            up_q       <= 1'b0;
            hold_len_q <= 0;
            lowrun_q   <= 0;
        end else begin
            up_q       <= 1'b1;
            hold_len_q <= in_hold ? hold_len_q + 1 : 0;
            if (drive_i)                lowrun_q <= 0;
            else if (lowrun_q < 100000) lowrun_q <= lowrun_q + 1;
        end
    end

    AST_FAULT_DRIVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fault_i |=> drive_i); // R2
    AST_DRIVE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (up_q && drive_i && !in_hold) |-> $past(fault_i)); // R2
    AST_QUIET_WHILE_DRIVING: assert property (@(posedge clk_i) disable iff (!rst_ni)
        drive_i |-> (st_i == ST_SETTLE || st_i == ST_HOLD)); // R8
    AST_HOLD_DRIVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        in_hold |-> drive_i); // R7
    AST_HOLD_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(in_hold) |-> (hold_len_q == int'(TMO_CYC))); // R7
    AST_SETTLE_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(st_i == ST_IDLE) |-> (lowrun_q >= int'(SETTLE_CYC) - 1)); // R9
endmodule

bind pbl_top pbl_chk #(.TMO_CYC(TMO_CYC), .SETTLE_CYC(SETTLE_CYC)) u_chk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fault_i(fault_req_i),
    .drive_i(drive_low_o),
    .st_i   (st_w)
);

// File: tb/pbl_top_tb_top.sv
`timescale 1ns/1ps
module pbl_top_tb_top;
    localparam int S   = 2;
    localparam int Q   = 4;
    localparam int D   = 12;
    localparam int T   = 30;
    localparam int SET = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fault = 1'b0;
    logic btn = 1'b0;
    logic line;
    logic drive;

    always #4 clk = ~clk; // 125 MHz

    // open-drain wire with pull-up: low if either side pulls
    assign line = ~(btn | drive);

    pbl_top #(
        .SYNC_STAGES(S), .GLITCH_CYC(Q), .DEB_CYC(D), .TMO_CYC(T), .SETTLE_CYC(SET)
    ) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .fault_req_i(fault),
        .line_lvl_i(line), .drive_low_o(drive)
    );

    typedef struct {
        int    cyc;
        bit    val;
        string tag;
    } exp_t;

    exp_t sbq[$];
    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;
    bit   prev_drv = 1'b1;
    exp_t mon_e;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, expv, cyc);
        end
    endtask

    task automatic push(input int c, input bit v, input string tag);
        exp_t e;
        e.cyc = c; e.val = v; e.tag = tag;
        sbq.push_back(e);
    endtask

    // monitor: every change of the drive must match the next expected item
    always @(negedge clk) begin
        if (!done && drive !== prev_drv) begin
            if (sbq.size() == 0) begin
                chk(1'b0, "unexpected drive change", int'(drive), int'(prev_drv));
            end else begin
                mon_e = sbq.pop_front();
                chk(mon_e.cyc == cyc, {mon_e.tag, " edge cycle"}, cyc, mon_e.cyc);
                chk(mon_e.val == drive, {mon_e.tag, " edge value"}, int'(drive), int'(mon_e.val));
            end
            prev_drv = drive;
        end
    end

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // predicted rise of the manual timeout: p = first low edge seen, r = final high edge
    function automatic int rise_at(input int p, input int r);
        return imax(r + S, p + S + Q + D + 1) + D;
    endfunction

    task automatic wait_to(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic btn_for(input bit v, input int n);
        btn = v;
        repeat (n) @(negedge clk);
    endtask

    int p, r, rs, m, f, pe;

    initial begin
        repeat (3) @(negedge clk);
        chk(drive == 1'b1, "R1 drive during reset", int'(drive), 1);
        push(cyc + 1, 1'b0, "R1 release after reset");
        rst_n = 1'b1;
        repeat (30) @(negedge clk);

        // R3: glitch of GLITCH_CYC cycles is ignored
        btn_for(1'b1, Q);
        btn = 1'b0;
        repeat (60) @(negedge clk);
        chk(drive == 1'b0, "R3 short low ignored", int'(drive), 0);

        // R4/R7: clean tap of GLITCH_CYC+1 cycles
        p = cyc + 1;
        btn_for(1'b1, Q + 1);
        r = cyc + 1;
        btn = 1'b0;
        rs = rise_at(p, r);
        push(rs, 1'b1, "R4 tap timeout start");
        push(rs + T, 1'b0, "R7 timeout length");
        wait_to(rs + T + SET + 20);

        // R5: bounce right after qualification is masked
        p = cyc + 1;
        btn_for(1'b1, 6);
        btn_for(1'b0, 3);
        btn_for(1'b1, 50);
        r = cyc + 1;
        btn = 1'b0;
        rs = rise_at(p, r);
        push(rs, 1'b1, "R5 masked bounce timeout start");
        push(rs + T, 1'b0, "R7 timeout length after bounce");
        wait_to(rs + T + SET + 20);

        // R6: release bounce restarts the release count
        p = cyc + 1;
        btn_for(1'b1, 40);
        btn_for(1'b0, 5);
        btn_for(1'b1, 3);
        btn_for(1'b0, 4);
        btn_for(1'b1, 2);
        r = cyc + 1;
        btn = 1'b0;
        rs = rise_at(p, r);
        push(rs, 1'b1, "R6 release debounce restart");
        push(rs + T, 1'b0, "R7 timeout after release bounce");
        wait_to(rs + T + SET + 20);

        // R2/R8: fault alone, own low level never starts a press
        fault = 1'b1;
        push(cyc + 1, 1'b1, "R2 fault rise");
        repeat (20) @(negedge clk);
        fault = 1'b0;
        push(cyc + 1, 1'b0, "R2 fault fall");
        repeat (80) @(negedge clk);
        chk(drive == 1'b0, "R8 no self trigger after fault", int'(drive), 0);

        // R10: fault overlapping and outlasting a manual timeout
        p = cyc + 1;
        btn_for(1'b1, Q + 1);
        r = cyc + 1;
        btn = 1'b0;
        rs = rise_at(p, r);
        push(rs, 1'b1, "R10 timeout start before fault");
        wait_to(rs + 5);
        fault = 1'b1;
        wait_to(rs + T + 10);
        chk(drive == 1'b1, "R10 drive held past timeout by fault", int'(drive), 1);
        fault = 1'b0;
        push(cyc + 1, 1'b0, "R10 release after fault");
        repeat (40) @(negedge clk);

        // R11: button held through a fault is recognised again
        btn_for(1'b1, 30);
        fault = 1'b1;
        push(cyc + 1, 1'b1, "R11 fault rise while held");
        repeat (20) @(negedge clk);
        fault = 1'b0;
        m = cyc + 1;
        push(m, 1'b0, "R11 fault fall while held");
        btn_for(1'b1, 40);
        r = cyc + 1;
        btn = 1'b0;
        pe = m + SET - S;
        rs = rise_at(pe, r);
        push(rs, 1'b1, "R11 timeout after held press");
        push(rs + T, 1'b0, "R11 timeout end");
        f = rs + T;
        wait_to(f);

        // R9: press wholly inside the settle window is ignored
        btn_for(1'b1, Q + 1);
        btn = 1'b0;
        repeat (60) @(negedge clk);
        chk(drive == 1'b0, "R9 press inside settle ignored", int'(drive), 0);

        // R9: press spanning the end of the settle window is recognised
        p = cyc + 1;
        btn_for(1'b1, Q + 1);
        r = cyc + 1;
        btn = 1'b0;
        rs = rise_at(p, r);
        push(rs, 1'b1, "R4 tap before settle test");
        push(rs + T, 1'b0, "R7 timeout before settle test");
        f = rs + T;
        wait_to(f);
        btn_for(1'b1, 14);
        r = cyc + 1;
        btn = 1'b0;
        pe = f + SET + 1 - S;
        rs = rise_at(pe, r);
        push(rs, 1'b1, "R9 press held past settle");
        push(rs + T, 1'b0, "R9 timeout end");
        wait_to(rs + T + 40);

        chk(sbq.size() == 0, "R7 all expected edges seen", sbq.size(), 0);
        chk(drive == 1'b0, "R8 line released at end", int'(drive), 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule